// File: doc/BRIEF.md
# Code-Set Pruning Search Engine

This block takes a transition graph over the code vectors of one bus segment and finds the widest data word that the segment can carry using only permitted transitions. Each code vector is a vertex. Row `v` of an internal adjacency matrix lists the vertices that may follow `v` on the bus. A data width `m` is feasible when some set of vertices exists in which every member has at least 2^m permitted successors inside that same set. Such a set lets a memory-based encoder map every m-bit word to a legal next code, whatever the current code is.

Software or a loader first writes the matrix one row at a time and then pulses `start`. The engine tries the widest candidate first. For each candidate width it sweeps over all vertices and drops any live vertex whose count of live successors is too small. It keeps sweeping until a sweep drops nothing. If enough vertices remain, it reports the width and the surviving set. If not, it narrows the width by one and restarts from the full vertex set. A pulse on `done` marks the end of a search. When even width zero finds no surviving vertex, the result is flagged as a failure.

Top module: `code_prune_top`

## Requirements
- R1: After reset, `done`, `busy` and `failed` are 0, `bestWidth` is 0 and `aliveMask` is all zeros.
- R2: A cycle with `wrEn` high while the engine is idle stores `wrRow` as row `wrAddr`. Bit d of row v set means the transition from code v to code d is permitted, and bit v counts as a self edge. A write presented while `busy` is high is discarded.
- R3: A search begins at width SEG_W-1 with every vertex alive. A graph in which every transition is permitted therefore yields `bestWidth` = SEG_W-1 with all vertices surviving.
- R4: At width m, a live vertex is removed when the population count of (its row AND the live mask) is below 2^m.
- R5: Each sweep visits vertices in ascending index order, and a removal is seen by all later visits in the same sweep. Sweeps repeat until one full sweep removes nothing. Each sweep takes one cycle per vertex.
- R6: After convergence, if at least 2^m vertices are alive, the engine reports `bestWidth` = m, `failed` = 0 and `aliveMask` equal to the live set.
- R7: If fewer than 2^m vertices are alive after convergence and m > 0, m is lowered by one and pruning restarts from the full vertex set.
- R8: If width 0 also fails, the engine reports `failed` = 1, `bestWidth` = 0 and an all-zero `aliveMask`.
- R9: `done` is high for exactly one cycle, in the same cycle that the new results first appear. `busy` is high from the cycle after an accepted `start` until that cycle. The results hold until the next search completes.
- R10: A `start` pulse while `busy` is high is ignored: the running search completes once and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Adjacency row write strobe |
| wrAddr | input | SEG_W | Row index (source code vector) |
| wrRow | input | 2^SEG_W | Permitted-destination bits for that row |
| start | input | 1 | Begin a search (accepted when idle) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| bestWidth | output | $clog2(SEG_W+1) | Accepted data width m |
| failed | output | 1 | No width, not even 0, was feasible |
| aliveMask | output | 2^SEG_W | Surviving vertex set for the reported width |

## Verification
The hardest behaviour to reach from the ports is the need for repeated sweeps. In that case a removal late in one sweep starves a vertex that was already visited, and the final result depends on rerunning the sweep. A forward chain (each code permits only its successor index, and the last code permits nothing) sheds exactly one vertex per sweep. A reverse chain sheds all vertices in a single sweep. Both end in failure, so the bench checks the completion-latency difference between the two, which must be exactly 31 extra sweeps of 32 cycles. A graph of permitted windows of eight destinations forces one width decrement. A graph of one self loop isolates width 0. Random graphs of several densities are compared against a bench model built from the requirements.

// File: rtl/code_prune_pkg.sv
package code_prune_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_CHECK
  } pruneState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadInit;
    logic scanStep;
    logic retryLower;
    logic accept;
    logic reject;
  } pruneCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic lastIdx;
    logic passRemoves;
    logic enough;
    logic widthZero;
  } pruneStat_t;

endpackage

// File: rtl/code_prune_datapath.sv
module code_prune_datapath
  import code_prune_pkg::*;
#(
  parameter int SEG_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  pruneCtl_t                      ctl,
  input  logic                           busy,
  input  logic                           wrEn,
  input  logic [SEG_W-1:0]               wrAddr,
  input  logic [(1<<SEG_W)-1:0]          wrRow,
  output pruneStat_t                     stat,
  output logic [$clog2(SEG_W+1)-1:0]     resWidth,
  output logic                           resFail,
  output logic [(1<<SEG_W)-1:0]          resMask
);

  localparam int NV = 1 << SEG_W;
  localparam int MW = $clog2(SEG_W + 1);
  localparam int CW = $clog2(NV + 1);

  logic [NV-1:0]    adjMem [NV];
  logic [NV-1:0]    alive;
  logic [SEG_W-1:0] scanIdx;
  logic [MW-1:0]    curWidth;
  logic             removed;

  logic [CW-1:0]    succCnt;
  logic [CW-1:0]    aliveCnt;
  logic [CW-1:0]    needCnt;
  logic             killNow;

  function automatic logic [CW-1:0] popCount(input logic [NV-1:0] vec);
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NV; i++) acc = acc + CW'(vec[i]);
    return acc;
  endfunction

  // adjacency storage, writable only while idle
  always_ff @(posedge clk) begin
    if (wrEn && !busy) adjMem[wrAddr] <= wrRow;
  end

  always_comb begin
    succCnt  = popCount(adjMem[scanIdx] & alive);
    aliveCnt = popCount(alive);
    needCnt  = CW'(1) << curWidth;
    killNow  = alive[scanIdx] && (succCnt < needCnt);
  end

  assign stat.lastIdx     = &scanIdx;
  assign stat.passRemoves = removed | killNow;
  assign stat.enough      = aliveCnt >= needCnt;
  assign stat.widthZero   = curWidth == '0;

  // working state of the search
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive    <= '0;
      scanIdx  <= '0;
      curWidth <= '0;
      removed  <= 1'b0;
    end else if (ctl.loadInit) begin
      alive    <= '1;
      scanIdx  <= '0;
      curWidth <= MW'(SEG_W - 1);
      removed  <= 1'b0;
    end else if (ctl.retryLower) begin
      alive    <= '1;
      scanIdx  <= '0;
      curWidth <= curWidth - 1'b1;
      removed  <= 1'b0;
    end else if (ctl.scanStep) begin
      if (killNow) alive[scanIdx] <= 1'b0;
      scanIdx <= scanIdx + 1'b1;
      removed <= stat.lastIdx ? 1'b0 : (removed | killNow);
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resWidth <= '0;
      resFail  <= 1'b0;
      resMask  <= '0;
    end else if (ctl.accept) begin
      resWidth <= curWidth;
      resFail  <= 1'b0;
      resMask  <= alive;
    end else if (ctl.reject) begin
      resWidth <= '0;
      resFail  <= 1'b1;
      resMask  <= alive;
    end
  end

  // R5
  alive_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.scanStep |=> ((alive & ~$past(alive)) == '0));

  // R6
  accept_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.accept |=> ($countones(resMask) >= (1 << resWidth)));

  // R8
  reject_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.reject |=> (resMask == '0 && resWidth == '0 && resFail));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.retryLower |-> (curWidth != '0));

endmodule

// File: rtl/code_prune_control.sv
module code_prune_control
  import code_prune_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  pruneStat_t stat,
  output pruneCtl_t  ctl,
  output logic       busy,
  output logic       done
);

  pruneState_e state, stateNxt;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.loadInit = 1'b1;
          stateNxt     = ST_SCAN;
        end
      end
      ST_SCAN: begin
        ctl.scanStep = 1'b1;
        if (stat.lastIdx && !stat.passRemoves) stateNxt = ST_CHECK;
      end
      ST_CHECK: begin
        if (stat.enough) begin
          ctl.accept = 1'b1;
          stateNxt   = ST_IDLE;
        end else if (stat.widthZero) begin
          ctl.reject = 1'b1;
          stateNxt   = ST_IDLE;
        end else begin
          ctl.retryLower = 1'b1;
          stateNxt       = ST_SCAN;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= ctl.accept | ctl.reject;
    end
  end

  assign busy = state != ST_IDLE;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  check_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK) |=> (state != ST_CHECK));

endmodule

// File: rtl/code_prune_top.sv
module code_prune_top
  import code_prune_pkg::*;
#(
  parameter int SEG_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wrEn,
  input  logic [SEG_W-1:0]           wrAddr,
  input  logic [(1<<SEG_W)-1:0]      wrRow,
  input  logic                       start,
  output logic                       busy,
  output logic                       done,
  output logic [$clog2(SEG_W+1)-1:0] bestWidth,
  output logic                       failed,
  output logic [(1<<SEG_W)-1:0]      aliveMask
);

  pruneCtl_t  ctl;
  pruneStat_t stat;

  code_prune_control ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .stat  (stat),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  code_prune_datapath #(.SEG_W(SEG_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .busy     (busy),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrRow    (wrRow),
    .stat     (stat),
    .resWidth (bestWidth),
    .resFail  (failed),
    .resMask  (aliveMask)
  );

endmodule

// File: tb/code_prune_tb.sv
`timescale 1ns/1ps
module code_prune_top_tb_top;

  localparam int SEG_W = 5;
  localparam int NV    = 1 << SEG_W;
  localparam int MW    = $clog2(SEG_W + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wrEn = 1'b0;
  logic [SEG_W-1:0]  wrAddr = '0;
  logic [NV-1:0]     wrRow = '0;
  logic              start = 1'b0;
  logic              busy, done, failed;
  logic [MW-1:0]     bestWidth;
  logic [NV-1:0]     aliveMask;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [NV-1:0] refAdj [NV];

  always #4 clk = ~clk;

  code_prune_top #(.SEG_W(SEG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrRow(wrRow),
    .start(start), .busy(busy), .done(done), .bestWidth(bestWidth),
    .failed(failed), .aliveMask(aliveMask)
  );

  task automatic checkVal(string req, string what, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic refSearch(output int w, output bit f, output logic [NV-1:0] mask);
    logic [NV-1:0] a;
    bit chg;
    a = '0;
    for (int m = SEG_W - 1; m >= 0; m--) begin
      a = '1;
      chg = 1;
      while (chg) begin
        chg = 0;
        for (int v = 0; v < NV; v++)
          if (a[v] && $countones(refAdj[v] & a) < (1 << m)) begin
            a[v] = 1'b0;
            chg = 1;
          end
      end
      if ($countones(a) >= (1 << m)) begin
        w = m; f = 0; mask = a;
        return;
      end
    end
    w = 0; f = 1; mask = a;
  endtask

  task automatic loadMatrix();
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = SEG_W'(v); wrRow = refAdj[v];
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // pulse start, wait for done; returns latency in cycles
  task automatic runSearch(string req, output int lat);
    int n;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checkVal("R9", "busy after start", busy, 1);
    n = 1;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    checkVal(req, "done seen", done, 1);
    lat = n;
  endtask

  task automatic runAndCompare(string req);
    int w, lat; bit f; logic [NV-1:0] mask;
    logic [MW-1:0] w0; logic [NV-1:0] m0;
    refSearch(w, f, mask);
    runSearch(req, lat);
    checkVal(req, "bestWidth", bestWidth, w);
    checkVal(req, "failed", failed, f);
    checkVal(req, "aliveMask", aliveMask, mask);
    w0 = bestWidth; m0 = aliveMask;
    @(negedge clk);
    checkVal("R9", "done single pulse", done, 0);
    checkVal("R9", "width holds", bestWidth, w0);
    checkVal("R9", "mask holds", aliveMask, m0);
  endtask

  task automatic testReset();
    checkVal("R1", "done", done, 0);
    checkVal("R1", "busy", busy, 0);
    checkVal("R1", "failed", failed, 0);
    checkVal("R1", "bestWidth", bestWidth, 0);
    checkVal("R1", "aliveMask", aliveMask, 0);
  endtask

  task automatic testFull();
    for (int v = 0; v < NV; v++) refAdj[v] = '1;
    loadMatrix();
    runAndCompare("R3");
    checkVal("R3", "top width direct", bestWidth, SEG_W - 1);
    checkVal("R3", "all alive direct", aliveMask, {NV{1'b1}});
  endtask

  task automatic testEmpty();
    for (int v = 0; v < NV; v++) refAdj[v] = '0;
    loadMatrix();
    runAndCompare("R8");
    checkVal("R8", "failed direct", failed, 1);
    checkVal("R8", "empty mask direct", aliveMask, 0);
  endtask

  task automatic testSelfLoop();
    for (int v = 0; v < NV; v++) refAdj[v] = '0;
    refAdj[5] = NV'(1) << 5;
    loadMatrix();
    runAndCompare("R4");
    checkVal("R4", "self edge width", bestWidth, 0);
    checkVal("R4", "self edge mask", aliveMask, NV'(1) << 5);
  endtask

  task automatic testClique();
    for (int v = 0; v < NV; v++)
      refAdj[v] = (v < NV / 2) ? NV'((1 << (NV / 2)) - 1) : NV'((1 << (NV / 2 - 1)) - 1);
    loadMatrix();
    runAndCompare("R6");
    checkVal("R6", "half set", aliveMask, NV'((1 << (NV / 2)) - 1));
  endtask

  task automatic testDecrement();
    for (int v = 0; v < NV; v++) begin
      refAdj[v] = '0;
      for (int k = 0; k < 8; k++) refAdj[v][(v + k) % NV] = 1'b1;
    end
    loadMatrix();
    runAndCompare("R7");
    checkVal("R7", "one step down", bestWidth, SEG_W - 2);
    checkVal("R7", "restart full set", aliveMask, {NV{1'b1}});
  endtask

  task automatic testSweepRepeat();
    int latFwd, latRev;
    for (int v = 0; v < NV; v++) refAdj[v] = (v < NV - 1) ? NV'(1) << (v + 1) : '0;
    loadMatrix();
    runSearch("R5", latFwd);
    checkVal("R5", "forward chain fails", failed, 1);
    checkVal("R5", "forward chain mask", aliveMask, 0);
    for (int v = 0; v < NV; v++) refAdj[v] = (v > 0) ? NV'(1) << (v - 1) : '0;
    loadMatrix();
    runSearch("R5", latRev);
    checkVal("R5", "reverse chain fails", failed, 1);
    checkVal("R5", "extra sweeps latency", latFwd - latRev, (NV - 1) * NV);
  endtask

  task automatic testRandom();
    for (int t = 0; t < 6; t++) begin
      int pct = 50 + t * 9;
      for (int v = 0; v < NV; v++)
        for (int d = 0; d < NV; d++) refAdj[v][d] = ($urandom_range(99) < pct);
      loadMatrix();
      runAndCompare("R4");
    end
  endtask

  task automatic testBusyIgnore();
    int lat, extra;
    for (int v = 0; v < NV; v++) refAdj[v] = '1;
    loadMatrix();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    wrEn = 1'b1; wrAddr = '0; wrRow = '0; start = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; start = 1'b0;
    lat = 0;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    checkVal("R10", "search completes", done, 1);
    extra = 0;
    repeat (60) begin
      @(negedge clk);
      if (done) extra++;
    end
    checkVal("R10", "no extra done", extra, 0);
    runAndCompare("R2");
    checkVal("R2", "busy write discarded", aliveMask, {NV{1'b1}});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testFull();
    testEmpty();
    testSelfLoop();
    testClique();
    testDecrement();
    testSweepRepeat();
    testRandom();
    testBusyIgnore();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule